// File: doc/BRIEF.md
# DRAM cycle type decoder

This block sits on the device side of an asynchronous DRAM strobe interface. It samples the row strobe, one column strobe per byte lane, the write strobe and the output-enable strobe in a system clock domain. For every row period it decides what kind of access is under way. It can serve as a protocol monitor beside a controller, or as the front end of a behavioural memory model that needs to know when to write a lane and when to drive it. All strobes are active low.

The access type follows the combined column strobe, meaning the logical OR of the lane strobes being active. The earliest lane to go low opens an access and the last lane to go high closes it. Write strobes and output enables are worked out separately for each byte lane. The block flags an error when the lanes of one access would disagree on the write type. The type, page indication and error are held through precharge until the next row strobe fall, so a monitor can read the finished cycle's class.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While rst_n is low at a clock edge, cycle_kind goes to 0 (standby) and page_mode, wr_lane, oe_lane and lane_conflict go to 0.
- R2: A row strobe fall with at least one lane strobe low selects kind 7 (CAS-before-RAS refresh). Later column strobe activity in that row period does not change the kind and never raises wr_lane or oe_lane.
- R3: A row strobe fall with all lane strobes high selects kind 1 (row open). If the row strobe rises while the kind is still 1, the kind becomes 6 (RAS-only refresh).
- R4: A combined column strobe fall during a row-open period selects kind 3 (early write) when the write strobe is low in that sample, and kind 2 (read) when it is high.
- R5: A write strobe fall while the kind is 2, the row strobe is low and a lane strobe is low selects kind 5 (read-modify-write) if a lane output was enabled earlier in that access, and kind 4 (delayed write) otherwise.
- R6: wr_lane[i] is 1 exactly when the row strobe, lane i's strobe and the write strobe are low and the kind is 3, 4 or 5. Bit 0 is the lower byte lane and bit 1 the upper.
- R7: oe_lane[i] is 1 exactly when the row strobe, lane i's strobe and the output-enable strobe are low, the write strobe is high, and the kind is 2, 4 or 5. It is never 1 in an early write or a refresh.
- R8: page_mode becomes 1 at the second combined column strobe fall within one row strobe low period. Each such fall reclassifies the access as kind 2 or 3 by the write strobe level.
- R9: lane_conflict becomes 1 when, within one access, two lanes fall with different write strobe levels. It stays 1 until the next row strobe fall.
- R10: cycle_kind, page_mode and lane_conflict keep their values after the row strobe rises, until the next row strobe fall.
- R11: Every output is registered. The inputs sampled at a clock edge are reflected on the outputs from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low, bit 0 is the lower lane |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| cycle_kind | output | 3 | Access type code: 0 standby, 1 row open, 2 read, 3 early write, 4 delayed write, 5 read-modify-write, 6 RAS-only refresh, 7 CAS-before-RAS refresh |
| page_mode | output | 1 | More than one column access in the current row period |
| wr_lane | output | LANES | Per-lane write strobe |
| oe_lane | output | LANES | Per-lane output drive enable |
| lane_conflict | output | 1 | Lanes disagreed on the write type within one access |

## Verification
Every result is due one clock after the inputs that cause it. The bench changes the inputs on the falling clock edge, lets one rising edge pass, and reads the outputs on the following falling edge. Each check therefore compares the state produced by exactly one new sample. Held values are checked by applying a further idle sample and confirming that nothing moved. The sweep covers every write-strobe level, output-enable level and lane pattern on a fresh access. Directed sequences cover refresh entry, delayed writes versus read-modify-writes, page accesses and staggered lanes.

// File: rtl/dcd_pkg.sv
// Shared types for the DRAM cycle decoder.
// Assumes: the numeric codes of kind_e are visible at the top ports and are stable.
package dcd_pkg;

    typedef enum logic [2:0] {
        KIND_IDLE = 3'd0,
        KIND_ROW  = 3'd1,
        KIND_READ = 3'd2,
        KIND_EWR  = 3'd3,
        KIND_DWR  = 3'd4,
        KIND_RMW  = 3'd5,
        KIND_RREF = 3'd6,
        KIND_CBR  = 3'd7
    } kind_e;

    // True for the access types that store data into the array.
    function automatic logic kind_writes(kind_e k);
        return (k == KIND_EWR) || (k == KIND_DWR) || (k == KIND_RMW);
    endfunction

    // True for the access types in which the outputs may drive.
    function automatic logic kind_drives(kind_e k);
        return (k == KIND_READ) || (k == KIND_DWR) || (k == KIND_RMW);
    endfunction

endpackage

// File: rtl/dcd_sampler.sv
// Keeps the previous sample of every strobe and derives edge events from it.
// Assumes: strobes are already synchronous to clk; the reset value of each is inactive (high).
module dcd_sampler #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    output logic             ras_fall,
    output logic             ras_rise,
    output logic             cas_any_low,
    output logic             cas_fall,
    output logic [LANES-1:0] lane_fall,
    output logic             we_fall
);
    logic             ras_q;
    logic [LANES-1:0] cas_q;
    logic             we_q;

    // Hold the previous sample of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= '1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    // Edge events: the combined strobe opens on the earliest lane and closes on the last.
    always_comb begin
        ras_fall    = ras_q & ~ras_n;
        ras_rise    = ~ras_q & ras_n;
        cas_any_low = ~&cas_n;
        cas_fall    = cas_any_low & (&cas_q);
        lane_fall   = cas_q & ~cas_n;
        we_fall     = we_q & ~we_n;
    end
endmodule

// File: rtl/dcd_classifier.sv
// Tracks the access type across one row period and counts column accesses.
// Assumes: edge events come from dcd_sampler for the same sample.
module dcd_classifier
    import dcd_pkg::*;
#(
    parameter int PAGE_AT = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ras_n,
    input  logic  we_n,
    input  logic  oe_n,
    input  logic  ras_fall,
    input  logic  ras_rise,
    input  logic  cas_any_low,
    input  logic  cas_fall,
    input  logic  we_fall,
    output kind_e kind_nxt,
    output kind_e kind_q,
    output logic  page_q
);
    localparam int CW = $clog2(PAGE_AT + 1);

    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          seen_q, seen_nxt;

    // Next access type from the current sample and the held type.
    always_comb begin
        kind_nxt = kind_q;
        if (ras_fall) begin
            kind_nxt = cas_any_low ? KIND_CBR : KIND_ROW;
        end else if (ras_rise) begin
            if (kind_q == KIND_ROW) kind_nxt = KIND_RREF;
        end else if (!ras_n && kind_q != KIND_CBR) begin
            if (cas_fall)
                kind_nxt = we_n ? KIND_READ : KIND_EWR;
            else if (we_fall && cas_any_low && kind_q == KIND_READ)
                kind_nxt = seen_q ? KIND_RMW : KIND_DWR;
        end
    end

    // Column access counter (saturating) and the "output already driven" flag.
    always_comb begin
        cnt_nxt  = cnt_q;
        seen_nxt = seen_q;
        if (ras_fall) begin
            cnt_nxt  = '0;
            seen_nxt = 1'b0;
        end else begin
            if (!ras_n && cas_fall && kind_q != KIND_CBR && cnt_q != CW'(PAGE_AT))
                cnt_nxt = cnt_q + 1'b1;
            if (cas_fall)
                seen_nxt = 1'b0;
            if (!ras_n && cas_any_low && we_n && !oe_n && kind_nxt == KIND_READ)
                seen_nxt = 1'b1;
        end
    end

    // State update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_IDLE;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            kind_q <= kind_nxt;
            cnt_q  <= cnt_nxt;
            seen_q <= seen_nxt;
        end
    end

    assign page_q = (cnt_q == CW'(PAGE_AT));
endmodule

// File: rtl/dcd_lanes.sv
// Per-lane write strobes, output enables and the cross-lane mode agreement check.
// Assumes: kind_nxt is the type chosen for the same sample by dcd_classifier.
module dcd_lanes
    import dcd_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             ras_fall,
    input  logic             cas_fall,
    input  logic [LANES-1:0] lane_fall,
    input  kind_e            kind_nxt,
    output logic [LANES-1:0] wr_q,
    output logic [LANES-1:0] oe_q,
    output logic             conflict_q
);
    logic [LANES-1:0] vld_q, vld_nxt;
    logic [LANES-1:0] early_q, early_nxt;
    logic             any_early, any_late;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic cap;
        assign cap          = lane_fall[g] & ~ras_n & (kind_nxt != KIND_CBR);
        assign vld_nxt[g]   = ras_fall ? 1'b0 : (cap ? 1'b1 : (cas_fall ? 1'b0 : vld_q[g]));
        assign early_nxt[g] = cap ? ~we_n : early_q[g];

        // Record this lane's write level at its own strobe fall; drive its strobes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g]   <= 1'b0;
                early_q[g] <= 1'b0;
                wr_q[g]    <= 1'b0;
                oe_q[g]    <= 1'b0;
            end else begin
                vld_q[g]   <= vld_nxt[g];
                early_q[g] <= early_nxt[g];
                wr_q[g]    <= ~ras_n & ~cas_n[g] & ~we_n & kind_writes(kind_nxt);
                oe_q[g]    <= ~ras_n & ~cas_n[g] & ~oe_n & we_n & kind_drives(kind_nxt);
            end
        end
    end

    assign any_early = |(vld_nxt & early_nxt);
    assign any_late  = |(vld_nxt & ~early_nxt);

    // Sticky disagreement flag, cleared when a new row period opens.
    always_ff @(posedge clk) begin
        if (!rst_n)        conflict_q <= 1'b0;
        else if (ras_fall) conflict_q <= 1'b0;
        else               conflict_q <= conflict_q | (any_early & any_late);
    end
endmodule

// File: rtl/dram_cycle_decoder.sv
// Top level: classifies DRAM strobe activity into access types per row period.
// Assumes: all strobes are active low and sampled on clk; reset is synchronous, active low.
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int PAGE_AT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic [2:0]       cycle_kind,
    output logic             page_mode,
    output logic [LANES-1:0] wr_lane,
    output logic [LANES-1:0] oe_lane,
    output logic             lane_conflict
);
    logic             ras_fall, ras_rise, cas_any_low, cas_fall, we_fall;
    logic [LANES-1:0] lane_fall;
    kind_e            kind_nxt, kind_q;

    dcd_sampler #(.LANES(LANES)) u_smp (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_any_low(cas_any_low),
        .cas_fall(cas_fall), .lane_fall(lane_fall), .we_fall(we_fall)
    );

    dcd_classifier #(.PAGE_AT(PAGE_AT)) u_cls (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .we_n(we_n), .oe_n(oe_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_any_low(cas_any_low),
        .cas_fall(cas_fall), .we_fall(we_fall),
        .kind_nxt(kind_nxt), .kind_q(kind_q), .page_q(page_mode)
    );

    dcd_lanes #(.LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .lane_fall(lane_fall),
        .kind_nxt(kind_nxt), .wr_q(wr_lane), .oe_q(oe_lane), .conflict_q(lane_conflict)
    );

    assign cycle_kind = kind_q;
endmodule

// File: rtl/dcd_checker.sv
// Protocol properties of dram_cycle_decoder, attached by bind.
// Assumes: the kind codes listed in the requirements.
module dcd_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [2:0]       cycle_kind,
    input logic             page_mode,
    input logic [LANES-1:0] wr_lane,
    input logic [LANES-1:0] oe_lane,
    input logic             lane_conflict
);
    assert_cbr_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !(&cas_n)) |=> (cycle_kind == 3'd7));

    assert_ras_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cycle_kind == 3'd1) && $rose(ras_n)) |=> (cycle_kind == 3'd6));

    assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_lane) |-> (!$past(ras_n) && !$past(we_n) && ((wr_lane & $past(cas_n)) == '0)));

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|oe_lane) |-> (!$past(ras_n) && !$past(oe_n) && $past(we_n) && ((oe_lane & $past(cas_n)) == '0)));

    assert_early_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd3) |-> (oe_lane == '0));

    assert_page_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_mode) |-> !$past(ras_n));

    assert_conflict_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !lane_conflict);
endmodule

bind dram_cycle_decoder dcd_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .cycle_kind(cycle_kind), .page_mode(page_mode), .wr_lane(wr_lane),
    .oe_lane(oe_lane), .lane_conflict(lane_conflict)
);

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic [1:0] cas_n = 2'b11;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [2:0] cycle_kind;
    logic       page_mode;
    logic [1:0] wr_lane;
    logic [1:0] oe_lane;
    logic       lane_conflict;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    dram_cycle_decoder uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .cycle_kind(cycle_kind), .page_mode(page_mode), .wr_lane(wr_lane),
        .oe_lane(oe_lane), .lane_conflict(lane_conflict)
    );

    // Drive one sample at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic apply(input logic r, input logic [1:0] c, input logic w, input logic o);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int ek, input logic [1:0] ew,
                       input logic [1:0] eo, input logic ep, input logic ec);
        checks++;
        if (cycle_kind !== 3'(ek) || wr_lane !== ew || oe_lane !== eo ||
            page_mode !== ep || lane_conflict !== ec) begin
            errors++;
            $display("FAIL %s: kind/wr/oe/page/conf actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                     tag, cycle_kind, wr_lane, oe_lane, page_mode, lane_conflict,
                     ek, ew, eo, ep, ec);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        apply(1'b0, 2'b00, 1'b0, 1'b0);      // activity during reset is ignored
        chk("R1 reset", 0, 2'b00, 2'b00, 1'b0, 1'b0);
        rst_n = 1'b1;
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R1 idle after reset", 0, 2'b00, 2'b00, 1'b0, 1'b0);

        // Sweep: write level x output-enable level x lane pattern on a fresh access
        for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 2; o++) begin
                for (int p = 1; p < 4; p++) begin
                    logic [1:0] pat;
                    pat = 2'(p);
                    apply(1'b1, 2'b11, 1'b1, 1'b1);
                    apply(1'b0, 2'b11, 1'b1, 1'b1);
                    chk("R3 row open", 1, 2'b00, 2'b00, 1'b0, 1'b0);
                    apply(1'b0, ~pat, w[0], o[0]);
                    chk("R4 R6 R7 access", (w != 0) ? 2 : 3,
                        (w != 0) ? 2'b00 : pat,
                        ((w != 0) && (o == 0)) ? pat : 2'b00, 1'b0, 1'b0);
                    apply(1'b0, 2'b11, w[0], o[0]);
                    chk("R6 R7 lanes released", (w != 0) ? 2 : 3, 2'b00, 2'b00, 1'b0, 1'b0);
                    apply(1'b1, 2'b11, 1'b1, 1'b1);
                end
            end
        end

        // RAS-only refresh
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R3 ras-only", 6, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R10 ras-only held", 6, 2'b00, 2'b00, 1'b0, 1'b0);

        // CAS-before-RAS refresh, lower lane first
        apply(1'b1, 2'b10, 1'b1, 1'b1);
        apply(1'b0, 2'b10, 1'b1, 1'b0);
        chk("R2 cbr entry", 7, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b00, 1'b1, 1'b0);
        chk("R2 R7 cbr no drive", 7, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b0, 2'b10, 1'b0, 1'b1);
        chk("R2 cbr no write", 7, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R10 cbr held", 7, 2'b00, 2'b00, 1'b0, 1'b0);

        // Delayed write
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b0, 2'b00, 1'b1, 1'b1);
        chk("R4 read first", 2, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b00, 1'b0, 1'b1);
        chk("R5 R11 delayed write", 4, 2'b11, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);

        // Read-modify-write
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b0, 2'b00, 1'b1, 1'b0);
        chk("R7 read drive", 2, 2'b00, 2'b11, 1'b0, 1'b0);
        apply(1'b0, 2'b00, 1'b1, 1'b1);
        apply(1'b0, 2'b00, 1'b0, 1'b1);
        chk("R5 rmw", 5, 2'b11, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);

        // Page mode: read then early write in one row period
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b0, 2'b10, 1'b1, 1'b1);
        chk("R8 first access", 2, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b0, 2'b10, 1'b0, 1'b1);
        chk("R8 R6 page early write", 3, 2'b01, 2'b00, 1'b1, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R10 page held", 3, 2'b00, 2'b00, 1'b1, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        chk("R8 page cleared", 1, 2'b00, 2'b00, 1'b0, 1'b0);

        // Lane conflict: lower lane delayed, upper lane early
        apply(1'b0, 2'b10, 1'b1, 1'b1);
        apply(1'b0, 2'b10, 1'b0, 1'b1);
        chk("R6 single lane delayed", 4, 2'b01, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b00, 1'b0, 1'b1);
        chk("R9 conflict", 4, 2'b11, 2'b00, 1'b0, 1'b1);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);
        chk("R9 R10 conflict held", 4, 2'b00, 2'b00, 1'b0, 1'b1);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        chk("R9 conflict cleared", 1, 2'b00, 2'b00, 1'b0, 1'b0);

        // Staggered lanes with matching write level: no conflict
        apply(1'b0, 2'b01, 1'b1, 1'b1);
        apply(1'b0, 2'b00, 1'b1, 1'b1);
        chk("R9 stagger agree", 2, 2'b00, 2'b00, 1'b0, 1'b0);
        apply(1'b0, 2'b11, 1'b1, 1'b1);
        apply(1'b1, 2'b11, 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule